// File: doc/BRIEF.md
# Coprocessor Error Port Decoder

This block sits on a PC-compatible I/O bus and owns the sixteen-address window that legacy software uses to talk to the math coprocessor. It looks after two pieces of state. The first is the coprocessor busy latch. The second is the coprocessor error interrupt line, which an external error input raises.

A byte write to offset 0 of the window clears the busy latch. A byte write to offset 1 sends a reset pulse to the coprocessor. Every byte write that lands in the window also drops the interrupt line. The block does not service the remaining cases:

- byte writes to any other offset, such as the opcode-transfer ports;
- writes of any other size;
- all reads.

For each of these it raises a one-cycle diagnostic flag and takes no other action. A read in the window sees the port as unused and returns all ones on the data bus.

Parameters set the address and data widths, the window base and size, and the length of the coprocessor reset pulse.

Top module: `fpe_errport_dec`

## Requirements
- R1: An access whose address lies outside BASE to BASE+2**WIN_LOG2-1 (default 0x00F0 to 0x00FF) has no effect: the flag stays low, the interrupt and busy outputs keep their values, and read data is zero.
- R2: A byte write (io_byte=1) to window offset 0 clears busy_o on the next clock edge.
- R3: A byte write to window offset 1 drives cop_rst_o high for exactly RST_PULSE_CYC cycles, starting in the cycle after the write.
- R4: Any byte write in the window drives irq_o low on the next clock edge, whatever its offset.
- R5: A byte write to any window offset other than 0 and 1 (including 8, 0xA and 0xC) raises unsup_o. It changes neither busy_o nor cop_rst_o.
- R6: A write in the window with io_byte=0 raises unsup_o and leaves irq_o, busy_o and cop_rst_o unchanged.
- R7: A read in the window raises unsup_o. While the read strobe is high, io_rdata is all ones.
- R8: unsup_o is registered. It goes high in the cycle after a flagged strobe and stays high for that one cycle only.
- R9: cop_err high sets irq_o on the next edge. If a clearing write arrives in the same cycle, cop_err wins.
- R10: busy_set high sets busy_o on the next edge. If an offset-0 clear arrives in the same cycle, busy_set wins.
- R11: During and immediately after reset, irq_o, busy_o, cop_rst_o and unsup_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_byte | input | 1 | 1 when the access is one byte wide |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | DATA_W | Read data, combinational from the read strobe |
| cop_err | input | 1 | Coprocessor error event, raises the interrupt |
| busy_set | input | 1 | Coprocessor sets its busy latch |
| busy_o | output | 1 | Busy latch state |
| irq_o | output | 1 | Coprocessor error interrupt request |
| cop_rst_o | output | 1 | Coprocessor reset pulse |
| unsup_o | output | 1 | One-cycle unsupported-access flag |

## Verification
The bench builds the block with the default 16-bit address, 32-bit data and base 0x00F0. It sets RST_PULSE_CYC to 3, so the counter variant of the reset stretcher is exercised and the bench can check both the pulse length and the cycle in which it ends. The 16-bit address lets the bench probe the addresses just below and just above the window. Same-cycle collisions of set and clear bring the priority rules within reach.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

   // Actions the window decoder requests for one bus cycle
   typedef struct packed {
      logic busy_clr;  // byte write to the busy-clear offset
      logic cop_rst;   // byte write to the reset offset
      logic irq_clr;   // any byte write inside the window
      logic unsup;     // access the block does not service
   } dec_out_t;

endpackage

// File: rtl/fpe_win_decode.sv
module fpe_win_decode
   import fpe_pkg::*;
#(
   parameter int unsigned          ADDR_W    = 16,
   parameter logic [ADDR_W-1:0]    BASE      = 16'h00F0,
   parameter int unsigned          WIN_LOG2  = 4,
   parameter int unsigned          OFS_BUSY  = 0,
   parameter int unsigned          OFS_RESET = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic              byte_acc,
   output logic              hit,
   output dec_out_t          dec
);
   localparam int unsigned HI_W = ADDR_W - WIN_LOG2;
   localparam logic [HI_W-1:0]     BASE_HI  = BASE[ADDR_W-1:WIN_LOG2];
   localparam logic [WIN_LOG2-1:0] O_BUSY   = WIN_LOG2'(OFS_BUSY);
   localparam logic [WIN_LOG2-1:0] O_RESET  = WIN_LOG2'(OFS_RESET);

   if (WIN_LOG2 < 1 || WIN_LOG2 >= ADDR_W) begin : g_bad_win
      $error("fpe_win_decode: WIN_LOG2 must lie in 1..ADDR_W-1");
   end
   if (OFS_BUSY == OFS_RESET || OFS_BUSY >= (1 << WIN_LOG2) || OFS_RESET >= (1 << WIN_LOG2)) begin : g_bad_ofs
      $error("fpe_win_decode: serviced offsets must differ and lie in the window");
   end

   logic [WIN_LOG2-1:0] ofs;
   logic                served_ofs;
   logic                wr_ok;

   always_comb begin
      ofs        = addr[WIN_LOG2-1:0];
      hit        = (addr[ADDR_W-1:WIN_LOG2] == BASE_HI);
      served_ofs = (ofs == O_BUSY) || (ofs == O_RESET);
      wr_ok      = hit && wr && byte_acc;

      dec.irq_clr  = wr_ok;
      dec.busy_clr = wr_ok && (ofs == O_BUSY);
      dec.cop_rst  = wr_ok && (ofs == O_RESET);
      dec.unsup    = hit && (rd || (wr && (!byte_acc || !served_ofs)));
   end
endmodule

// File: rtl/fpe_sr_flag.sv
module fpe_sr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // set dominates a simultaneous clear
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/fpe_pulse_stretch.sv
module fpe_pulse_stretch #(
   parameter int unsigned LEN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic pulse
);
   if (LEN < 1) begin : g_bad_len
      $error("fpe_pulse_stretch: LEN must be at least 1");
   end

   if (LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) pulse <= 1'b0;
         else        pulse <= req;
      end
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(LEN + 1);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(LEN);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)              cnt <= '0;
         else if (req)            cnt <= LOAD;
         else if (cnt != '0)      cnt <= cnt - 1'b1;
      end
      assign pulse = (cnt != '0);

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= LOAD) else $error("stretch counter out of range"); // R3
   end
endmodule

// File: rtl/fpe_errport_dec.sv
module fpe_errport_dec
   import fpe_pkg::*;
#(
   parameter int unsigned       ADDR_W        = 16,
   parameter int unsigned       DATA_W        = 32,
   parameter logic [ADDR_W-1:0] BASE          = 16'h00F0,
   parameter int unsigned       WIN_LOG2      = 4,
   parameter int unsigned       RST_PULSE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_byte,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              cop_err,
   input  logic              busy_set,
   output logic              busy_o,
   output logic              irq_o,
   output logic              cop_rst_o,
   output logic              unsup_o
);
   localparam int unsigned OFS_BUSY  = 0;
   localparam int unsigned OFS_RESET = 1;

   if (DATA_W < 8) begin : g_bad_data
      $error("fpe_errport_dec: DATA_W must be at least 8");
   end

   logic     win_hit;
   dec_out_t dec;

   fpe_win_decode #(
      .ADDR_W   (ADDR_W),
      .BASE     (BASE),
      .WIN_LOG2 (WIN_LOG2),
      .OFS_BUSY (OFS_BUSY),
      .OFS_RESET(OFS_RESET)
   ) i_decode (
      .addr     (io_addr),
      .wr       (io_wr),
      .rd       (io_rd),
      .byte_acc (io_byte),
      .hit      (win_hit),
      .dec      (dec)
   );

   fpe_sr_flag i_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (cop_err),
      .clr   (dec.irq_clr),
      .q     (irq_o)
   );

   fpe_sr_flag i_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (busy_set),
      .clr   (dec.busy_clr),
      .q     (busy_o)
   );

   fpe_pulse_stretch #(.LEN(RST_PULSE_CYC)) i_rst (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (dec.cop_rst),
      .pulse (cop_rst_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) unsup_o <= 1'b0;
      else        unsup_o <= dec.unsup;
   end

   // unused port: reads in the window float high
   assign io_rdata = (io_rd && win_hit) ? '1 : '0;

   AST_OUTSIDE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_hit && !cop_err && !busy_set) |=> (!unsup_o && $stable(irq_o) && $stable(busy_o))) else $error("outside access acted"); // R1
   AST_BUSY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.busy_clr && !busy_set) |=> !busy_o) else $error("busy not cleared"); // R2
   AST_RST_START: assert property (@(posedge clk) disable iff (!rst_n)
      dec.cop_rst |=> cop_rst_o) else $error("reset pulse missing"); // R3
   AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_byte && win_hit && !cop_err) |=> !irq_o) else $error("irq not dropped"); // R4
   AST_NONBYTE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_byte && !cop_err && !busy_set) |=> ($stable(irq_o) && $stable(busy_o))) else $error("non-byte write acted"); // R6
   AST_READ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && win_hit) |=> unsup_o) else $error("read not flagged"); // R7
   AST_FLAG_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_rd && !io_wr) |=> !unsup_o) else $error("flag without strobe"); // R8
   AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cop_err |=> irq_o) else $error("error did not set irq"); // R9
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_set |=> busy_o) else $error("busy set lost"); // R10
endmodule

// File: tb/test_fpe_errport_dec.sv
module test_fpe_errport_dec;
   localparam int unsigned ADDR_W = 16;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned RLEN   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] io_addr = '0;
   logic              io_byte = 1'b0;
   logic              io_wr = 1'b0;
   logic              io_rd = 1'b0;
   logic [DATA_W-1:0] io_rdata;
   logic              cop_err = 1'b0;
   logic              busy_set = 1'b0;
   logic              busy_o, irq_o, cop_rst_o, unsup_o;

   always #5 clk = ~clk;

   fpe_errport_dec #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(16'h00F0),
      .WIN_LOG2(4), .RST_PULSE_CYC(RLEN)
   ) i_fpe_errport_dec (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_byte(io_byte),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
      .cop_err(cop_err), .busy_set(busy_set), .busy_o(busy_o),
      .irq_o(irq_o), .cop_rst_o(cop_rst_o), .unsup_o(unsup_o)
   );

   typedef struct {
      logic              irq, busy, rst, unsup;
      logic [DATA_W-1:0] rdata;
      string             tag;
   } exp_t;

   exp_t q[$];
   int   vectors = 0;
   int   miscompares = 0;
   bit   done = 1'b0;

   // reference state kept from the requirements
   logic m_irq = 0, m_busy = 0, m_unsup = 0;
   int   m_rcnt = 0;
   string prev_tag = "R11";

   task automatic cyc(input logic [ADDR_W-1:0] a, input logic wr, input logic rd,
                      input logic byt, input logic err, input logic bset, input string tag);
      exp_t e;
      logic hit, wok;
      logic [3:0] ofs;
      @(posedge clk); #2;
      io_addr = a; io_wr = wr; io_rd = rd; io_byte = byt;
      cop_err = err; busy_set = bset;
      hit = (a[ADDR_W-1:4] == 12'h00F);
      ofs = a[3:0];
      e.irq = m_irq; e.busy = m_busy; e.rst = (m_rcnt != 0); e.unsup = m_unsup;
      e.rdata = (hit && rd) ? '1 : '0;
      e.tag = {prev_tag, "/", tag};
      q.push_back(e);
      wok = hit && wr && byt;
      if (err) m_irq = 1; else if (wok) m_irq = 0;
      if (bset) m_busy = 1; else if (wok && ofs == 4'h0) m_busy = 0;
      if (wok && ofs == 4'h1) m_rcnt = RLEN; else if (m_rcnt > 0) m_rcnt--;
      m_unsup = hit && (rd || (wr && (!byt || (ofs != 4'h0 && ofs != 4'h1))));
      prev_tag = tag;
   endtask

   task automatic idle(input string tag);
      cyc('0, 0, 0, 0, 0, 0, tag);
   endtask

   // monitor: compare at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            vectors++;
            if (irq_o !== e.irq || busy_o !== e.busy || cop_rst_o !== e.rst ||
                unsup_o !== e.unsup || io_rdata !== e.rdata) begin
               miscompares++;
               $display("FAIL %s: act irq=%b busy=%b rst=%b unsup=%b rdata=%h exp irq=%b busy=%b rst=%b unsup=%b rdata=%h",
                        e.tag, irq_o, busy_o, cop_rst_o, unsup_o, io_rdata,
                        e.irq, e.busy, e.rst, e.unsup, e.rdata);
            end
         end
      end
   end

   initial begin
      #(200_000 * 10);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: act hung exp finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      idle("R11");
      idle("R11");
      cyc('0, 0, 0, 0, 1, 0, "R9");          // error raises irq
      cyc('0, 0, 0, 0, 0, 1, "R10");         // busy latch set
      cyc(16'h00F0, 1, 0, 1, 0, 0, "R2");    // clear busy, drop irq
      idle("R8");
      cyc('0, 0, 0, 0, 1, 1, "R9");
      cyc(16'h00F1, 1, 0, 1, 0, 0, "R3");    // reset pulse
      idle("R3"); idle("R3"); idle("R3"); idle("R3");
      cyc('0, 0, 0, 0, 1, 0, "R9");
      cyc(16'h00F8, 1, 0, 1, 0, 0, "R5");    // opcode port
      cyc('0, 0, 0, 0, 1, 0, "R9");
      cyc(16'h00FA, 1, 0, 1, 0, 0, "R5");
      cyc(16'h00FC, 1, 0, 1, 1, 0, "R9");    // err wins over clear
      cyc(16'h00FF, 1, 0, 1, 0, 0, "R4");
      idle("R8");
      cyc('0, 0, 0, 0, 1, 0, "R9");
      cyc(16'h00F0, 1, 0, 0, 0, 0, "R6");    // word write, inert
      cyc(16'h00F1, 1, 0, 0, 0, 0, "R6");
      idle("R6"); idle("R6");
      cyc(16'h00F3, 0, 1, 1, 0, 0, "R7");    // read, all ones
      cyc(16'h00F0, 0, 1, 0, 0, 0, "R7");
      idle("R8");
      cyc(16'h00EF, 1, 0, 1, 0, 0, "R1");    // just below window
      cyc(16'h0100, 1, 0, 1, 0, 0, "R1");    // just above window
      cyc(16'h0100, 0, 1, 1, 0, 0, "R1");
      cyc(16'h01F0, 1, 0, 1, 0, 0, "R1");
      cyc(16'h00F0, 1, 0, 1, 0, 1, "R10");   // set wins over clear
      cyc(16'h00F0, 1, 0, 1, 0, 0, "R2");
      cyc(16'h00F1, 1, 0, 1, 0, 0, "R3");
      idle("R3");
      cyc(16'h00F1, 1, 0, 1, 0, 0, "R3");    // retrigger reloads
      idle("R3"); idle("R3"); idle("R3"); idle("R3");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule